// File: doc/BRIEF.md
# Conditional floating-point move unit

This unit decides whether a 32-bit floating-point source value replaces the current contents of a destination register slot. One of six move conditions is picked by a 4-bit opcode. Four of them test a 32-bit integer register: equal to zero, non-zero, negative as a signed value, and non-negative as a signed value. The other two test one bit, chosen by a 4-bit index, of a 16-bit boolean register: one moves when the bit is clear, the other when it is set. The register files stay outside the unit. The unit reads the present destination value and the test operands, and it returns the next destination value, a write-enable and a flag for reserved opcodes.

Requests enter on a valid/ready stream and results leave on a second valid/ready stream through a single register stage. A request is taken on any rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output slot is empty or the downstream side takes the result on that same edge, so sustained traffic runs at one request per cycle. If `out_ready` stays low while a result is waiting, the result is held unchanged and `in_ready` drops until the result is taken.

Top module: `cfmov_unit`

## Requirements
- R1: Opcode 8 asserts write-enable and outputs the source when the integer test value equals zero.
- R2: Opcode 9 asserts write-enable and outputs the source when the integer test value is non-zero.
- R3: Opcode 10 asserts write-enable and outputs the source when bit 31 of the integer test value is 1 (negative as a signed value).
- R4: Opcode 11 asserts write-enable and outputs the source when bit 31 of the integer test value is 0 (greater than or equal to zero as a signed value).
- R5: Opcode 12 asserts write-enable and outputs the source when boolean bit `in_idx` (0 = LSB) is 0.
- R6: Opcode 13 asserts write-enable and outputs the source when boolean bit `in_idx` is 1.
- R7: When an opcode from 8 to 13 finds its condition false, write-enable is low, the reserved flag is low, and `out_data` equals the destination value that was supplied.
- R8: A move copies all 32 bits of the source unchanged, including sign and NaN payload bits.
- R9: Opcodes 0 to 7, 14 and 15 set `out_reserved`, hold write-enable low, and return the supplied destination value.
- R10: A result appears on the output one clock edge after its request is taken. While `out_valid` is high and `out_ready` is low, the result stays stable and `in_ready` is low.
- R11: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A request is presented |
| in_ready | output | 1 | The unit takes the request on this edge |
| in_op | input | 4 | Move opcode (8..13 valid) |
| in_src | input | 32 | Float source bit pattern |
| in_dest | input | 32 | Current destination value |
| in_ival | input | 32 | Integer test value |
| in_bools | input | 16 | Boolean register |
| in_idx | input | 4 | Boolean bit index |
| out_valid | output | 1 | A result is presented |
| out_ready | input | 1 | Downstream takes the result |
| out_data | output | 32 | Next destination value |
| out_wen | output | 1 | Destination write-enable |
| out_reserved | output | 1 | Opcode was reserved |

## Verification
A wrong condition decode shows up on the very next output beat: `out_wen` takes the wrong level and `out_data` holds the wrong one of source and destination, so every request is checked one edge after it is taken. A bad boolean index select only shows when the indexed bit differs from its neighbours, so random boolean registers are combined with the end indices 0 and 15. Broken stall handling shows as a result changing, being lost, or being repeated while `out_ready` is low. The bench therefore matches results to requests in order under random back-pressure, and also runs a long directed stall.

// File: rtl/cfmov_pkg.sv
package cfmov_pkg;
  localparam logic [3:0] OP_MOV_IZ   = 4'd8;
  localparam logic [3:0] OP_MOV_INZ  = 4'd9;
  localparam logic [3:0] OP_MOV_NEG  = 4'd10;
  localparam logic [3:0] OP_MOV_NNEG = 4'd11;
  localparam logic [3:0] OP_MOV_BF   = 4'd12;
  localparam logic [3:0] OP_MOV_BT   = 4'd13;

  typedef struct packed {
    logic rsvd;
    logic take;
  } verdict_t;
endpackage

// File: rtl/cfmov_cond.sv
module cfmov_cond
  import cfmov_pkg::*;
#(
  parameter int INT_W  = 32,
  parameter int BOOL_N = 16,
  parameter int IDX_W  = 4
) (
  input  logic [3:0]       op,
  input  logic [INT_W-1:0] ival,
  input  logic [BOOL_N-1:0] bools,
  input  logic [IDX_W-1:0] idx,
  output verdict_t         verdict
);
  localparam int SEL_SPAN = 1 << IDX_W;

  logic bit_sel;
  logic is_zero;
  logic is_neg;

  generate
    if (SEL_SPAN <= BOOL_N) begin : g_full_index
      assign bit_sel = bools[idx];
    end else begin : g_guarded_index
      logic [SEL_SPAN-1:0] padded;
      assign padded  = {{(SEL_SPAN-BOOL_N){1'b0}}, bools};
      assign bit_sel = padded[idx];
    end
  endgenerate

  assign is_zero = (ival == '0);
  assign is_neg  = ival[INT_W-1];

  always_comb begin
    verdict.rsvd = 1'b0;
    verdict.take = 1'b0;
    unique case (op)
      OP_MOV_IZ:   verdict.take = is_zero;
      OP_MOV_INZ:  verdict.take = !is_zero;
      OP_MOV_NEG:  verdict.take = is_neg;
      OP_MOV_NNEG: verdict.take = !is_neg;
      OP_MOV_BF:   verdict.take = !bit_sel;
      OP_MOV_BT:   verdict.take = bit_sel;
      default:     verdict.rsvd = 1'b1;
    endcase
  end
endmodule

// File: rtl/cfmov_stage.sv
module cfmov_stage #(
  parameter int W = 34
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_payload,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_payload
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_payload <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_payload <= in_payload;
    end
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_payload)));

  assert_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
endmodule

// File: rtl/cfmov_unit.sv
module cfmov_unit
  import cfmov_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int INT_W  = 32,
  parameter int BOOL_N = 16,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        in_op,
  input  logic [DATA_W-1:0] in_src,
  input  logic [DATA_W-1:0] in_dest,
  input  logic [INT_W-1:0]  in_ival,
  input  logic [BOOL_N-1:0] in_bools,
  input  logic [IDX_W-1:0]  in_idx,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_wen,
  output logic              out_reserved
);
  localparam int PAY_W = DATA_W + 2;

  verdict_t          verdict;
  logic [DATA_W-1:0] next_val;
  logic [PAY_W-1:0]  pay_in;
  logic [PAY_W-1:0]  pay_out;

  cfmov_cond #(.INT_W(INT_W), .BOOL_N(BOOL_N), .IDX_W(IDX_W)) u_cond (
    .op(in_op), .ival(in_ival), .bools(in_bools), .idx(in_idx),
    .verdict(verdict)
  );

  assign next_val = verdict.take ? in_src : in_dest;
  assign pay_in   = {verdict.rsvd, verdict.take, next_val};

  cfmov_stage #(.W(PAY_W)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_payload(pay_in),
    .out_valid(out_valid), .out_ready(out_ready), .out_payload(pay_out)
  );

  assign out_reserved = pay_out[PAY_W-1];
  assign out_wen      = pay_out[PAY_W-2];
  assign out_data     = pay_out[DATA_W-1:0];

  assert_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !verdict.take) |=> (!out_wen && out_data == $past(in_dest)));

  assert_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && verdict.take) |=> (out_wen && out_data == $past(in_src)));

  assert_rsvd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_reserved) |-> !out_wen);

  assert_rsvd_op_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (in_op < 4'd8 || in_op > 4'd13)) |=> out_reserved);
endmodule

// File: tb/cfmov_unit_test.sv
module cfmov_unit_test;
  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] src;
    logic [31:0] dest;
    logic [31:0] ival;
    logic [15:0] bools;
    logic [3:0]  idx;
  } req_t;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic        in_ready;
  logic [3:0]  in_op = 0;
  logic [31:0] in_src = 0, in_dest = 0, in_ival = 0;
  logic [15:0] in_bools = 0;
  logic [3:0]  in_idx = 0;
  logic        out_valid;
  logic        out_ready = 1;
  logic [31:0] out_data;
  logic        out_wen;
  logic        out_reserved;

  int checks = 0;
  int fails = 0;
  int ready_mode = 0; // 0 always ready, 1 random, 2 never
  bit finished = 0;
  req_t q[$];

  cfmov_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_src(in_src), .in_dest(in_dest), .in_ival(in_ival),
    .in_bools(in_bools), .in_idx(in_idx), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_wen(out_wen),
    .out_reserved(out_reserved)
  );

  always #5 clk = ~clk;

  function automatic logic [33:0] model(req_t r);
    logic rs, tk;
    rs = 0; tk = 0;
    case (r.op)
      4'd8:  tk = (r.ival == 0);
      4'd9:  tk = (r.ival != 0);
      4'd10: tk = r.ival[31];
      4'd11: tk = !r.ival[31];
      4'd12: tk = !r.bools[r.idx];
      4'd13: tk = r.bools[r.idx];
      default: rs = 1;
    endcase
    return {rs, tk, tk ? r.src : r.dest};
  endfunction

  function automatic string tag_of(req_t r, logic [33:0] e);
    if (e[33]) return "R9";
    if (!e[32]) return "R7";
    case (r.op)
      4'd8:  return "R1,R8";
      4'd9:  return "R2,R8";
      4'd10: return "R3,R8";
      4'd11: return "R4,R8";
      4'd12: return "R5,R8";
      default: return "R6,R8";
    endcase
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: sample at negedge, inputs/outputs stable before next edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (out_valid && out_ready) begin
        if (q.size() == 0) begin
          check(0, "R10", {31'd0, out_wen, out_data}, 64'd0);
        end else begin
          req_t r;
          logic [33:0] e;
          r = q.pop_front();
          e = model(r);
          check({out_reserved, out_wen, out_data} == e, tag_of(r, e),
                {30'd0, out_reserved, out_wen, out_data}, {30'd0, e});
        end
      end
      if (in_valid && in_ready) begin
        q.push_back({in_op, in_src, in_dest, in_ival, in_bools, in_idx});
      end
    end
  end

  always @(posedge clk) begin
    #1;
    case (ready_mode)
      0: out_ready = 1;
      1: out_ready = ($urandom_range(0, 2) != 0);
      default: out_ready = 0;
    endcase
  end

  task automatic send(req_t r);
    bit acc;
    in_valid = 1;
    {in_op, in_src, in_dest, in_ival, in_bools, in_idx} = r;
    acc = 0;
    while (!acc) begin
      @(negedge clk);
      acc = in_ready;
      @(posedge clk); #1;
    end
    in_valid = 0;
  endtask

  function automatic logic [31:0] pick_ival();
    case ($urandom_range(0, 5))
      0: return 32'h0000_0000;
      1: return 32'h8000_0000;
      2: return 32'h7fff_ffff;
      3: return 32'hffff_ffff;
      4: return 32'h0000_0001;
      default: return $urandom();
    endcase
  endfunction

  function automatic req_t mk(logic [3:0] op, logic [31:0] src, logic [31:0] dest,
                              logic [31:0] iv, logic [15:0] b, logic [3:0] ix);
    return {op, src, dest, iv, b, ix};
  endfunction

  initial begin
    repeat (40000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(out_valid == 0 && in_ready == 1, "R11", {62'd0, out_valid, in_ready}, 64'd1);
    @(posedge clk); #1;

    // directed corners
    send(mk(4'd8,  32'h3f80_0000, 32'h1111_1111, 32'h0, 16'h0, 4'd0));   // R1 take
    send(mk(4'd8,  32'h3f80_0000, 32'h1111_1111, 32'h1, 16'h0, 4'd0));   // R7
    send(mk(4'd9,  32'h7fc1_2345, 32'h2222_2222, 32'h8000_0000, 0, 0));  // R2 NaN R8
    send(mk(4'd9,  32'h7fc1_2345, 32'h2222_2222, 32'h0, 0, 0));          // R7
    send(mk(4'd10, 32'hffa0_0001, 32'h3333_3333, 32'h8000_0000, 0, 0));  // R3
    send(mk(4'd10, 32'hffa0_0001, 32'h3333_3333, 32'h7fff_ffff, 0, 0));  // R7
    send(mk(4'd11, 32'h8000_0000, 32'h4444_4444, 32'h0, 0, 0));          // R4 zero
    send(mk(4'd11, 32'h8000_0000, 32'h4444_4444, 32'hffff_ffff, 0, 0));  // R7
    send(mk(4'd12, 32'h4049_0fdb, 32'h5555_5555, 0, 16'hfffe, 4'd0));    // R5
    send(mk(4'd12, 32'h4049_0fdb, 32'h5555_5555, 0, 16'h8000, 4'd15));   // R7
    send(mk(4'd13, 32'hff80_0000, 32'h6666_6666, 0, 16'h8000, 4'd15));   // R6
    send(mk(4'd13, 32'hff80_0000, 32'h6666_6666, 0, 16'hfffe, 4'd0));    // R7
    send(mk(4'd0,  32'habcd_ef01, 32'h7777_7777, 0, 16'hffff, 4'd3));    // R9
    send(mk(4'd7,  32'habcd_ef01, 32'h7777_7777, 0, 0, 0));              // R9
    send(mk(4'd14, 32'habcd_ef01, 32'h7777_7777, 0, 0, 0));              // R9
    send(mk(4'd15, 32'habcd_ef01, 32'h7777_7777, 0, 0, 0));              // R9

    // directed stall: R10
    ready_mode = 2;
    @(posedge clk); #1;
    send(mk(4'd8, 32'hdead_beef, 32'h0, 32'h0, 0, 0));
    @(negedge clk);
    held = out_data;
    repeat (3) @(negedge clk);
    check(out_valid && !in_ready && out_data == held, "R10",
          {30'd0, out_valid, in_ready, out_data}, {30'd2, held});
    ready_mode = 0;
    repeat (3) @(posedge clk); #1;

    // random traffic under random back-pressure
    ready_mode = 1;
    for (int i = 0; i < 400; i++) begin
      req_t r;
      r.op = ($urandom_range(0, 3) != 0) ? 4'(8 + $urandom_range(0, 5)) : 4'($urandom_range(0, 15));
      r.src = $urandom();
      r.dest = $urandom();
      r.ival = pick_ival();
      r.bools = 16'($urandom());
      r.idx = ($urandom_range(0, 3) == 0) ? 4'd15 : 4'($urandom_range(0, 15));
      send(r);
      if ($urandom_range(0, 4) == 0) begin
        @(posedge clk); #1;
      end
    end
    ready_mode = 0;
    repeat (10) @(posedge clk);
    check(q.size() == 0, "R10", 64'(q.size()), 64'd0);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule